// File: doc/BRIEF.md
# Multi-Cycle Multiply/Divide Sequencer

This block sits in the execute stage of a pipelined processor. It handles the multiply, divide and remainder instructions that need more than one clock. When such an instruction is valid in EX, a three-state sequencer sends a single-cycle launch strobe to one of two units. Division goes to a radix-2 restoring divider that settles one quotient bit per clock. Multiplication goes to a multiplier with a fixed, parameterised latency.

From the first cycle the instruction is seen until the result is ready, the block asserts a stall request that the surrounding pipeline merges into its back-end stall. On the completion cycle the combinational unit output is routed straight to the result port and a done pulse fires, so no extra register stage is spent. The same value is also written into a holding register. If the back end is still frozen on that cycle, the result is served from that register until the pipeline moves the instruction on, and the instruction is never launched a second time.

The operation code is three bits, `{kind[1:0], signed}`. The kinds are: 00 low half of the product, 01 high half of the product, 10 quotient, 11 remainder. Bit 0 set selects the signed (two's complement) form and clear selects the unsigned form.

Top module: `muldiv_sequencer`

## Requirements
- R1: While and directly after reset, with no instruction valid, `stallReq` and `donePulse` are low.
- R2: `stallReq` is high in every cycle from the first cycle `exValid` is seen in the idle state up to, but not including, the done cycle, and it is low in the done cycle.
- R3: Counting the clock edge that samples `exValid` in the idle state as edge 1, `donePulse` is high after edge W+2 (34 for W=32) for opCode[2]=1 (divide class) and after edge MUL_LAT+2 (6 by default) for opCode[2]=0 (multiply class). The launch strobe lasts one cycle.
- R4: Multiply results: kind 00 gives the low 32 bits of the product (the same for both signed forms). Kind 01 gives the high 32 bits of the 64-bit product, with operands sign-extended when opCode[0]=1 and zero-extended when opCode[0]=0.
- R5: Divide results truncate toward zero. Kind 10 gives the quotient and kind 11 the remainder, and the remainder takes the sign of the dividend in the signed form. The most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R6: A zero divisor gives quotient 0xFFFFFFFF and a remainder equal to the dividend, in both signed and unsigned forms, with the normal divide latency.
- R7: `donePulse` lasts exactly one cycle, and `result` carries the correct value in that same cycle.
- R8: If `backStall` is high in the done cycle, `result` keeps the value and `stallReq` and `donePulse` stay low, even with `exValid` high, until `backStall` drops. After the instruction leaves, the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exValid | input | 1 | A multi-cycle arithmetic instruction is valid in EX |
| opCode | input | 3 | {kind[1:0], signed} operation select |
| opA | input | 32 | First operand (multiplicand or dividend) |
| opB | input | 32 | Second operand (multiplier or divisor) |
| backStall | input | 1 | Pipeline back-end stall; high means EX does not advance |
| stallReq | output | 1 | Stall request while an operation runs |
| result | output | 32 | Operation result, valid in the done cycle and while held |
| donePulse | output | 1 | One-cycle completion strobe |

## Verification
A sequencer stuck in the wait state, or one that relaunches, appears at the ports as a stall that never clears, or as a stall that comes back after the done cycle without a new instruction. It is seen within one cycle of the expected completion. An off-by-one iteration count in either unit moves `donePulse` by a cycle, and it also changes the divider's quotient bits, so both the latency check and the value check catch it. A bad sign fix-up or zero-divisor path shows in the result on the done cycle itself. A lost holding register shows as a changed `result` on the cycle after done while `backStall` is held high.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_STARTED = 2'd1,
    SEQ_WAIT    = 2'd2
  } seq_state_e;

  // kind field of opCode[2:1]
  typedef enum logic [1:0] {
    KIND_MUL_LO = 2'b00,
    KIND_MUL_HI = 2'b01,
    KIND_DIV_Q  = 2'b10,
    KIND_DIV_R  = 2'b11
  } op_kind_e;

  typedef struct packed {
    logic start;    // one-cycle launch to the selected unit
    logic capture;  // load the holding register
    logic useHeld;  // drive result from the holding register
  } seq_strobe_t;

endpackage

// File: rtl/muldiv_divider.sv
module muldiv_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         isSigned,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0] remR, quoR, dvsR;
  logic         negQ, negR, zeroDiv, busy;
  logic [CW-1:0] cnt;

  logic [W-1:0] magA, magB;
  assign magA = (isSigned && dividend[W-1]) ? -dividend : dividend;
  assign magB = (isSigned && divisor[W-1])  ? -divisor  : divisor;

  logic [W:0]   shifted;
  logic [W-1:0] diffLow;
  logic         fits;
  assign shifted = {remR, quoR[W-1]};
  assign fits    = shifted >= {1'b0, dvsR};
  assign diffLow = shifted[W-1:0] - dvsR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remR <= '0; quoR <= '0; dvsR <= '0;
      negQ <= 1'b0; negR <= 1'b0; zeroDiv <= 1'b0;
      busy <= 1'b0; cnt <= '0;
    end else if (start) begin
      remR    <= '0;
      quoR    <= magA;
      dvsR    <= magB;
      negQ    <= isSigned && (dividend[W-1] ^ divisor[W-1]);
      negR    <= isSigned && dividend[W-1];
      zeroDiv <= (divisor == '0);
      busy    <= 1'b1;
      cnt     <= CW'(W);
    end else if (busy) begin
      if (cnt != '0) begin
        remR <= fits ? diffLow : shifted[W-1:0];
        quoR <= {quoR[W-2:0], fits};
        cnt  <= cnt - CW'(1);
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assign done = busy && (cnt == '0);
  assign quot = (negQ && !zeroDiv) ? -quoR : quoR;
  assign rem  = negR ? -remR : remR;

endmodule

// File: rtl/muldiv_multiplier.sv
module muldiv_multiplier #(
  parameter int W   = 32,
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         isSigned,
  input  logic [W-1:0] mulA,
  input  logic [W-1:0] mulB,
  output logic         done,
  output logic [W-1:0] prodLo,
  output logic [W-1:0] prodHi
);
  localparam int CW = $clog2(LAT + 1);

  logic [W:0]    aR, bR;   // sign- or zero-extended operands
  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aR <= '0; bR <= '0; cnt <= '0; busy <= 1'b0;
    end else if (start) begin
      aR   <= {isSigned & mulA[W-1], mulA};
      bR   <= {isSigned & mulB[W-1], mulB};
      cnt  <= CW'(LAT);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt != '0) cnt <= cnt - CW'(1);
      else           busy <= 1'b0;
    end
  end

  logic signed [2*W-1:0] extA, extB, prod;
  assign extA = {{(W-1){aR[W]}}, aR};
  assign extB = {{(W-1){bR[W]}}, bR};
  assign prod = extA * extB;

  assign done   = busy && (cnt == '0);
  assign prodLo = prod[W-1:0];
  assign prodHi = prod[2*W-1:W];

endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath
  import muldiv_pkg::*;
#(
  parameter int W       = 32,
  parameter int MUL_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  seq_strobe_t strb,
  input  logic [2:0]  opCode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic        unitDone,
  output logic [W-1:0] result
);
  logic [1:0] kindR;
  logic       divStart, mulStart, divDone, mulDone;
  logic [W-1:0] quot, rem, prodLo, prodHi, unitResult, heldR;

  assign divStart = strb.start &&  opCode[2];
  assign mulStart = strb.start && !opCode[2];

  muldiv_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(divStart), .isSigned(opCode[0]),
    .dividend(opA), .divisor(opB), .done(divDone), .quot(quot), .rem(rem)
  );

  muldiv_multiplier #(.W(W), .LAT(MUL_LAT)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(mulStart), .isSigned(opCode[0]),
    .mulA(opA), .mulB(opB), .done(mulDone), .prodLo(prodLo), .prodHi(prodHi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kindR <= '0;
      heldR <= '0;
    end else begin
      if (strb.start)   kindR <= opCode[2:1];
      if (strb.capture) heldR <= unitResult;
    end
  end

  always_comb begin
    case (op_kind_e'(kindR))
      KIND_MUL_LO: unitResult = prodLo;
      KIND_MUL_HI: unitResult = prodHi;
      KIND_DIV_Q:  unitResult = quot;
      default:     unitResult = rem;
    endcase
  end

  assign unitDone = kindR[1] ? divDone : mulDone;
  assign result   = strb.useHeld ? heldR : unitResult;

endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exValid,
  input  logic        backStall,
  input  logic        unitDone,
  output seq_strobe_t strb,
  output logic        stallReq,
  output logic        donePulse
);
  seq_state_e state, nextState;
  logic       held, nextHeld;

  always_comb begin
    nextState = state;
    nextHeld  = held;
    strb      = '0;
    stallReq  = 1'b0;
    donePulse = 1'b0;
    case (state)
      SEQ_IDLE: begin
        if (exValid) begin
          stallReq  = 1'b1;
          nextState = SEQ_STARTED;
        end
      end
      SEQ_STARTED: begin
        strb.start = 1'b1;
        stallReq   = 1'b1;
        nextState  = SEQ_WAIT;
      end
      SEQ_WAIT: begin
        if (held) begin
          strb.useHeld = 1'b1;
          if (!backStall) begin
            nextState = SEQ_IDLE;
            nextHeld  = 1'b0;
          end
        end else if (unitDone) begin
          donePulse    = 1'b1;
          strb.capture = 1'b1;
          if (backStall) nextHeld  = 1'b1;
          else           nextState = SEQ_IDLE;
        end else begin
          stallReq = 1'b1;
        end
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      held  <= 1'b0;
    end else begin
      state <= nextState;
      held  <= nextHeld;
    end
  end

endmodule

// File: rtl/muldiv_sequencer.sv
module muldiv_sequencer
  import muldiv_pkg::*;
#(
  parameter int MUL_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exValid,
  input  logic [2:0]  opCode,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        backStall,
  output logic        stallReq,
  output logic [31:0] result,
  output logic        donePulse
);
  seq_strobe_t strb;
  logic        unitDone;

  muldiv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .exValid(exValid), .backStall(backStall),
    .unitDone(unitDone), .strb(strb), .stallReq(stallReq), .donePulse(donePulse)
  );

  muldiv_datapath #(.W(32), .MUL_LAT(MUL_LAT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .opCode(opCode),
    .opA(opA), .opB(opB), .unitDone(unitDone), .result(result)
  );

endmodule

// File: rtl/muldiv_sequencer_chk.sv
module muldiv_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        backStall,
  input logic        stallReq,
  input logic        donePulse,
  input logic [31:0] result,
  input logic        startPulse
);
  // R3: the launch strobe is a single cycle and only occurs while stalling
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse);
  p_start_in_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> stallReq);
  // R2: stall only falls on the completion cycle, and is low there
  p_stall_falls_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stallReq) |-> donePulse);
  p_no_stall_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |-> !stallReq);
  // R7: completion strobe lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |=> !donePulse);
  // R8: held result is stable and the instruction is not relaunched
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (donePulse && backStall) |=> ($stable(result) && !stallReq));
endmodule

bind muldiv_sequencer muldiv_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .backStall(backStall), .stallReq(stallReq),
  .donePulse(donePulse), .result(result), .startPulse(strb.start)
);

// File: tb/muldiv_sequencer_test.sv
`timescale 1ns/1ps
module muldiv_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        backStall = 1'b0;
  logic        stallReq, donePulse;
  logic [31:0] result;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [31:0] rnd = 32'h1234_5677;

  localparam int MUL_LAT = 4;

  always #5 clk = ~clk;

  muldiv_sequencer #(.MUL_LAT(MUL_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .exValid(exValid), .opCode(opCode),
    .opA(opA), .opB(opB), .backStall(backStall),
    .stallReq(stallReq), .result(result), .donePulse(donePulse)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refCalc(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    logic [31:0] q, r;
    case (op[2:1])
      2'b00: return a * b;
      2'b01: begin
        if (op[0]) p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        else       p = {32'b0, a} * {32'b0, b};
        return p[63:32];
      end
      default: begin
        if (b == 32'd0) begin
          q = 32'hFFFF_FFFF; r = a;
        end else if (op[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
          q = 32'h8000_0000; r = 32'd0;
        end else if (op[0]) begin
          q = $signed(a) / $signed(b); r = $signed(a) % $signed(b);
        end else begin
          q = a / b; r = a % b;
        end
        return op[1] ? r : q;
      end
    endcase
  endfunction

  function automatic logic [31:0] nextRnd(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // One instruction through EX; entered and left at a falling edge.
  task automatic runOp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input int hold, input string req);
    int n;
    bit stallOk;
    logic [31:0] exp;
    exp = refCalc(op, a, b);
    exValid = 1'b1; opCode = op; opA = a; opB = b; backStall = (hold > 0);
    #1;
    n = 0; stallOk = 1'b1;
    while (!donePulse && n < 80) begin
      if (!stallReq) stallOk = 1'b0;
      @(posedge clk); @(negedge clk); #1;
      n++;
    end
    check(stallOk && !stallReq, "R2 stall held until done", {31'b0, stallReq}, 32'd0);
    check(n == (op[2] ? 34 : MUL_LAT + 2), "R3 latency", n, op[2] ? 34 : MUL_LAT + 2);
    check(result == exp, req, result, exp);
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); @(negedge clk); #1;
      check(result == exp && !stallReq && !donePulse, "R8 held result, no relaunch", result, exp);
    end
    exValid = 1'b0; backStall = 1'b0;
    @(posedge clk); @(negedge clk); #1;
    check(!stallReq && !donePulse, hold > 0 ? "R8 idle after leave" : "R7 single done pulse",
          {30'b0, stallReq, donePulse}, 32'd0);
  endtask

  task automatic testReset();
    #1;
    check(!stallReq && !donePulse, "R1 in reset", {30'b0, stallReq, donePulse}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    check(!stallReq && !donePulse, "R1 after reset", {30'b0, stallReq, donePulse}, 32'd0);
  endtask

  task automatic testMultiply();
    runOp(3'b000, 32'd7, 32'd6, 0, "R4 mul low unsigned");
    runOp(3'b001, 32'hFFFF_FFFD, 32'd5, 0, "R4 mul low signed");
    runOp(3'b011, 32'hFFFF_FFFD, 32'd5, 0, "R4 mul high signed");
    runOp(3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R4 mul high unsigned");
    runOp(3'b011, 32'h8000_0000, 32'h8000_0000, 0, "R4 mul high signed min*min");
  endtask

  task automatic testDivide();
    runOp(3'b101, 32'hFFFF_FFF9, 32'd2, 0, "R5 signed quotient -7/2");
    runOp(3'b111, 32'hFFFF_FFF9, 32'd2, 0, "R5 signed remainder -7%2");
    runOp(3'b111, 32'd7, 32'hFFFF_FFFE, 0, "R5 signed remainder 7%-2");
    runOp(3'b100, 32'hFFFF_FFF9, 32'd2, 0, "R5 unsigned quotient");
    runOp(3'b110, 32'd100, 32'd7, 0, "R5 unsigned remainder");
    runOp(3'b101, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R5 min/-1 quotient");
    runOp(3'b111, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R5 min/-1 remainder");
  endtask

  task automatic testDivZero();
    runOp(3'b101, 32'hFFFF_FF00, 32'd0, 0, "R6 signed div by zero quotient");
    runOp(3'b111, 32'hFFFF_FF00, 32'd0, 0, "R6 signed div by zero remainder");
    runOp(3'b100, 32'h1234_5678, 32'd0, 0, "R6 unsigned div by zero quotient");
    runOp(3'b110, 32'h1234_5678, 32'd0, 0, "R6 unsigned div by zero remainder");
  endtask

  task automatic testHold();
    runOp(3'b001, 32'd1234, 32'd5678, 3, "R8 mul result under back stall");
    runOp(3'b101, 32'hFFFF_0000, 32'd3, 2, "R8 div result under back stall");
  endtask

  task automatic testRandom();
    for (int k = 0; k < 24; k++) begin
      logic [31:0] a, b;
      rnd = nextRnd(rnd); a = rnd;
      rnd = nextRnd(rnd); b = (k % 5 == 4) ? (rnd >> 28) : rnd;
      runOp(3'(k % 8), a, b, 0, (k % 8) < 4 ? "R4 random multiply" : "R5 random divide");
    end
  endtask

  initial begin
    #2_000_000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testMultiply();
    testDivide();
    testDivZero();
    testHold();
    testRandom();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule